// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between a command sequencer and a single SDRAM bank. It decides, cycle by cycle, whether the offered command may be issued without breaking the device's minimum command spacings. It holds a 32-bit timing word in two copies: a staged copy that software writes, and an active copy that the spacing logic uses. The staged word is copied into the active one only on a rising edge of a separate apply input. A word that contains an illegal timing code is refused, and the block raises an error pulse.

Commands arrive on a valid/ready port. `cmd_ready` is a combinational function of `cmd_code` and the internal timing state. It never depends on `cmd_valid`, so a requester may look at ready before it commits. A command is issued in the cycle where `cmd_valid` and `cmd_ready` are both high. When ready is low, a well-behaved requester holds its command until ready goes high. It may also withdraw the command or replace it, which has no effect on the block.

Each spacing is kept by its own down-counter. The counter is loaded with the required clock count minus one when its triggering command is issued. The block also outputs the active CAS latency and a read-valid strobe that marks the cycle in which the first read datum is due.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset, the staged readback is 0x2A733220, `cas_latency` is 2, `load_err` and `rd_valid` are 0, and an ACT offered in the first cycle is ready.
- R2: When `cfg_wr_en` is high, the staged word takes `cfg_wr_data` with bits 31, 19, 15, 11, 7 and 3:0 forced to zero. The new value appears on `cfg_rd_data` in the next cycle, and the active timings and `cas_latency` do not change.
- R3: A rising edge of `cfg_apply` copies a legal staged word into the active word. The staged value used is the one held before that clock edge, and the new timings govern from the next cycle on. Holding `cfg_apply` high does not copy again.
- R4: A rising edge of `cfg_apply` is refused when the staged word is illegal. The word is illegal if any 3-bit field (CL 30:28, tRP 18:16, tRCD 14:12, tRRD 10:8, tDPL 6:4) is 000, if CL is 001, or if a 4-bit field (tRC 27:24, tRAS 23:20) is 0000. On a refusal the active word is kept and `load_err` is high for exactly the next cycle.
- R5: A 3-bit code n stands for n clocks. A 4-bit code n stands for n+1 clocks. A spacing of N clocks means that a command issued in cycle t allows the constrained command from cycle t+N on.
- R6: ACT is held off for tRC after a REF, for tRP after a PRE, and for tRRD after an ACT.
- R7: After an ACT, no further ACT is ready until a READ or WRITE has been issued.
- R8: READ (code 2) and WRITE (code 3) are held off for tRCD after an ACT (code 1).
- R9: PRE (code 4) is held off for tRAS after an ACT and for tDPL after a WRITE. A WRITE carries a single datum in its own cycle.
- R10: REF (code 5) is held off for tRC after a REF.
- R11: `cmd_ready` is high in every cycle in which the offered command meets all of its spacings. Codes 0, 6 and 7 are never ready and leave the timing state unchanged.
- R12: `rd_valid` is high for one cycle, exactly CL cycles after the cycle in which a READ was issued.
- R13: `cas_latency` always shows the active CL code, which is never below 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the staged timing word |
| cfg_wr_data | input | 32 | Data for the staged timing word |
| cfg_apply | input | 1 | Program bit; a rising edge copies the staged word into the active word |
| cfg_rd_data | output | 32 | Staged word readback, with reserved bits zero |
| load_err | output | 1 | One-cycle pulse after a refused apply |
| cmd_valid | input | 1 | A command is offered |
| cmd_code | input | 3 | Command: 1 ACT, 2 READ, 3 WRITE, 4 PRE, 5 REF |
| cmd_ready | output | 1 | The offered code may be issued this cycle |
| cas_latency | output | 3 | Active CAS latency in clocks |
| rd_valid | output | 1 | The first read datum of an issued READ is due |

## Verification
The bound checker watches every cycle. It checks that only supported codes are ever issued and that no second ACT is issued before a READ or WRITE. It checks the tRP and tRCD gaps against values it latches itself, that the error pulse lasts exactly one cycle, and that the CAS latency moves only after an apply edge and never drops below 2. Other behaviours can only be shown by the bench's scenarios, because they need a model of the programmed timing sets: that every spacing opens on exactly its first legal cycle, the code-to-clock mappings at their extremes, refused loads that leave the old timings in place, and read strobes landing CL cycles after each READ.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;
  localparam int REG_W    = 32;
  localparam int CMD_W    = 3;
  localparam int CNT_W    = 4;
  localparam int NUM_GAPS = 6;
  localparam int MAX_CL   = 7;

  localparam logic [REG_W-1:0] CFG_MASK  = 32'h7FF7_7770;
  localparam logic [REG_W-1:0] CFG_RESET = 32'h2A73_3225 & CFG_MASK;

  localparam logic [CMD_W-1:0] CMD_ACT = 3'd1;
  localparam logic [CMD_W-1:0] CMD_RD  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_WR  = 3'd3;
  localparam logic [CMD_W-1:0] CMD_PRE = 3'd4;
  localparam logic [CMD_W-1:0] CMD_REF = 3'd5;

  localparam int G_RC  = 0;
  localparam int G_RAS = 1;
  localparam int G_RP  = 2;
  localparam int G_RCD = 3;
  localparam int G_RRD = 4;
  localparam int G_DPL = 5;

  typedef struct packed {
    logic [2:0] cl;
    logic [3:0] rc;
    logic [3:0] ras;
    logic [2:0] rp;
    logic [2:0] rcd;
    logic [2:0] rrd;
    logic [2:0] dpl;
  } timing_t;

  function automatic timing_t unpack_cfg(logic [REG_W-1:0] r);
    timing_t t;
    t.cl  = r[30:28];
    t.rc  = r[27:24];
    t.ras = r[23:20];
    t.rp  = r[18:16];
    t.rcd = r[14:12];
    t.rrd = r[10:8];
    t.dpl = r[6:4];
    return t;
  endfunction

  function automatic logic cfg_legal(timing_t t);
    return (t.cl > 3'd1) && (t.rc != 4'd0) && (t.ras != 4'd0) &&
           (t.rp != 3'd0) && (t.rcd != 3'd0) && (t.rrd != 3'd0) &&
           (t.dpl != 3'd0);
  endfunction

  // 3-bit code n -> n clocks -> reload n-1
  function automatic logic [CNT_W-1:0] reload3(logic [2:0] c);
    return CNT_W'(c) - CNT_W'(1);
  endfunction

  // 4-bit code n -> n+1 clocks -> reload n
  function automatic logic [CNT_W-1:0] reload4(logic [3:0] c);
    return CNT_W'(c);
  endfunction
endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] reload,
  output logic         idle
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (load)
      count_q <= reload;
    else if (count_q != '0)
      count_q <= count_q - W'(1);
  end

  assign idle = (count_q == '0);
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import sdram_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             apply,
  output logic [REG_W-1:0] stage_out,
  output logic [REG_W-1:0] active_out,
  output logic             load_err
);
  logic [REG_W-1:0] stage_q, active_q;
  logic             apply_q, err_q;
  logic             rise, ok;

  assign rise = apply && !apply_q;
  assign ok   = cfg_legal(unpack_cfg(stage_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= CFG_RESET;
      active_q <= CFG_RESET;
      apply_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      apply_q <= apply;
      err_q   <= rise && !ok;
      if (rise && ok)
        active_q <= stage_q;
      if (wr_en)
        stage_q <= wr_data & CFG_MASK;
    end
  end

  assign stage_out  = stage_q;
  assign active_out = active_q;
  assign load_err   = err_q;
endmodule

// File: rtl/read_pipe.sv
module read_pipe #(
  parameter int DEPTH = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [2:0] cl,
  output logic       valid_out
);
  logic [DEPTH-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)
      shreg <= '0;
    else
      shreg <= {shreg[DEPTH-2:0], fire};
  end

  always_comb begin
    valid_out = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (32'(cl) == i + 1)
        valid_out = shreg[i];
  end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  input  logic             cfg_apply,
  output logic [REG_W-1:0] cfg_rd_data,
  output logic             load_err,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             cmd_ready,
  output logic [2:0]       cas_latency,
  output logic             rd_valid
);
  logic [REG_W-1:0] active_cfg;
  timing_t          tm;
  logic             accept;
  logic             issue_act, issue_rd, issue_wr, issue_pre, issue_ref;
  logic             act_open_q;
  logic [NUM_GAPS-1:0] gap_load, gap_idle;
  logic [CNT_W-1:0]    gap_reload [NUM_GAPS];

  cfg_bank u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .apply      (cfg_apply),
    .stage_out  (cfg_rd_data),
    .active_out (active_cfg),
    .load_err   (load_err)
  );

  assign tm = unpack_cfg(active_cfg);

  assign accept    = cmd_valid && cmd_ready;
  assign issue_act = accept && (cmd_code == CMD_ACT);
  assign issue_rd  = accept && (cmd_code == CMD_RD);
  assign issue_wr  = accept && (cmd_code == CMD_WR);
  assign issue_pre = accept && (cmd_code == CMD_PRE);
  assign issue_ref = accept && (cmd_code == CMD_REF);

  always_comb begin
    gap_load[G_RC]    = issue_ref;
    gap_load[G_RAS]   = issue_act;
    gap_load[G_RP]    = issue_pre;
    gap_load[G_RCD]   = issue_act;
    gap_load[G_RRD]   = issue_act;
    gap_load[G_DPL]   = issue_wr;
    gap_reload[G_RC]  = reload4(tm.rc);
    gap_reload[G_RAS] = reload4(tm.ras);
    gap_reload[G_RP]  = reload3(tm.rp);
    gap_reload[G_RCD] = reload3(tm.rcd);
    gap_reload[G_RRD] = reload3(tm.rrd);
    gap_reload[G_DPL] = reload3(tm.dpl);
  end

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    gap_timer #(.W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (gap_load[g]),
      .reload (gap_reload[g]),
      .idle   (gap_idle[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      act_open_q <= 1'b0;
    else if (issue_act)
      act_open_q <= 1'b1;
    else if (issue_rd || issue_wr)
      act_open_q <= 1'b0;
  end

  always_comb begin
    case (cmd_code)
      CMD_ACT: cmd_ready = gap_idle[G_RC] && gap_idle[G_RP] &&
                           gap_idle[G_RRD] && !act_open_q;
      CMD_RD,
      CMD_WR:  cmd_ready = gap_idle[G_RCD];
      CMD_PRE: cmd_ready = gap_idle[G_RAS] && gap_idle[G_DPL];
      CMD_REF: cmd_ready = gap_idle[G_RC];
      default: cmd_ready = 1'b0;
    endcase
  end

  read_pipe #(.DEPTH(MAX_CL)) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (issue_rd),
    .cl        (tm.cl),
    .valid_out (rd_valid)
  );

  assign cas_latency = tm.cl;
endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [2:0]  cmd_code,
  input logic        cfg_apply,
  input logic        load_err,
  input logic [2:0]  cas_latency,
  input logic [31:0] act_cfg
);
  logic       acc, acc_act, acc_rw, acc_pre;
  logic       ap_d, open_q;
  logic [4:0] since_pre, since_act;
  logic [2:0] need_rp_q, need_rcd_q;

  assign acc     = cmd_valid && cmd_ready;
  assign acc_act = acc && cmd_code == 3'd1;
  assign acc_rw  = acc && (cmd_code == 3'd2 || cmd_code == 3'd3);
  assign acc_pre = acc && cmd_code == 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_d       <= 1'b0;
      open_q     <= 1'b0;
      since_pre  <= 5'd31;
      since_act  <= 5'd31;
      need_rp_q  <= 3'd0;
      need_rcd_q <= 3'd0;
    end else begin
      ap_d <= cfg_apply;
      if (acc_act) open_q <= 1'b1;
      else if (acc_rw) open_q <= 1'b0;
      if (acc_pre) begin
        since_pre <= 5'd1;
        need_rp_q <= act_cfg[18:16];
      end else if (since_pre != 5'd31) since_pre <= since_pre + 5'd1;
      if (acc_act) begin
        since_act  <= 5'd1;
        need_rcd_q <= act_cfg[14:12];
      end else if (since_act != 5'd31) since_act <= since_act + 5'd1;
    end
  end

  AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (cmd_code >= 3'd1 && cmd_code <= 3'd5)); // R11
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> !load_err); // R4
  AST_CL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_apply && !ap_d) |=> $stable(cas_latency)); // R3
  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cas_latency >= 3'd2); // R13
  AST_ACT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_act |-> !open_q); // R7
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_act |-> since_pre >= {2'b00, need_rp_q}); // R6
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rw |-> since_act >= {2'b00, need_rcd_q}); // R8
endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_code    (cmd_code),
  .cfg_apply   (cfg_apply),
  .load_err    (load_err),
  .cas_latency (cas_latency),
  .act_cfg     (active_cfg)
);

// File: tb/sdram_cmd_guard_test.sv
`timescale 1ns/1ps
module sdram_cmd_guard_test;
  localparam logic [31:0] MASK = 32'h7FF7_7770;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_apply = 1'b0;
  logic [31:0] cfg_rd_data;
  logic        load_err;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic        cmd_ready;
  logic [2:0]  cas_latency;
  logic        rd_valid;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sdram_cmd_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_apply(cfg_apply), .cfg_rd_data(cfg_rd_data), .load_err(load_err),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
    .cas_latency(cas_latency), .rd_valid(rd_valid)
  );

  // reference model
  int          cyc = 0;
  int          t_ref = -100, t_act = -100, t_pre = -100, t_wr = -100;
  int          n_rc = 0, n_ras = 0, n_rp = 0, n_rcd = 0, n_rrd = 0, n_dpl = 0;
  bit          open_act = 0;
  logic [31:0] m_stage  = 32'h2A73_3225 & MASK;
  logic [31:0] m_active = 32'h2A73_3225 & MASK;
  bit          m_err = 0;
  bit          ap_prev = 0;
  bit          exp_rv [64];
  bit          last_acc;

  function automatic int clk3(logic [2:0] c); return int'(c); endfunction
  function automatic int clk4(logic [3:0] c); return int'(c) + 1; endfunction

  function automatic bit legal(logic [31:0] r);
    return r[30:28] > 3'd1 && r[27:24] != 0 && r[23:20] != 0 && r[18:16] != 0 &&
           r[14:12] != 0 && r[10:8] != 0 && r[6:4] != 0;
  endfunction

  function automatic bit exp_ready(logic [2:0] c);
    case (c)
      3'd1: return (cyc - t_ref >= n_rc) && (cyc - t_pre >= n_rp) &&
                   (cyc - t_act >= n_rrd) && !open_act;
      3'd2, 3'd3: return cyc - t_act >= n_rcd;
      3'd4: return (cyc - t_act >= n_ras) && (cyc - t_wr >= n_dpl);
      3'd5: return cyc - t_ref >= n_rc;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd1: return "R6/R7 R5";
      3'd2, 3'd3: return "R8 R5";
      3'd4: return "R9 R5";
      3'd5: return "R10 R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic do_cycle(input bit v, input logic [2:0] c, input bit we,
                          input logic [31:0] wd, input bit ap);
    bit er;
    @(negedge clk);
    cmd_valid = v; cmd_code = c; cfg_wr_en = we; cfg_wr_data = wd; cfg_apply = ap;
    #1;
    er = exp_ready(c);
    check(cmd_ready == er, tag_of(c), int'(cmd_ready), int'(er));
    check(rd_valid == exp_rv[cyc % 64], "R12", int'(rd_valid), int'(exp_rv[cyc % 64]));
    exp_rv[cyc % 64] = 0;
    check(load_err == m_err, "R4", int'(load_err), int'(m_err));
    check(cas_latency == m_active[30:28], "R13", int'(cas_latency), int'(m_active[30:28]));
    check(cfg_rd_data == m_stage, "R2", int'(cfg_rd_data), int'(m_stage));
    last_acc = v && er;
    if (last_acc) begin
      case (c)
        3'd1: begin t_act = cyc; open_act = 1; n_ras = clk4(m_active[23:20]);
                    n_rcd = clk3(m_active[14:12]); n_rrd = clk3(m_active[10:8]); end
        3'd2: begin open_act = 0; exp_rv[(cyc + clk3(m_active[30:28])) % 64] = 1; end
        3'd3: begin open_act = 0; t_wr = cyc; n_dpl = clk3(m_active[6:4]); end
        3'd4: begin t_pre = cyc; n_rp = clk3(m_active[18:16]); end
        3'd5: begin t_ref = cyc; n_rc = clk4(m_active[27:24]); end
        default: ;
      endcase
    end
    m_err = 0;
    if (ap && !ap_prev) begin
      if (legal(m_stage)) m_active = m_stage;
      else m_err = 1;
    end
    ap_prev = ap;
    if (we) m_stage = wd & MASK;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_cycle(0, 3'd0, 0, '0, 0);
  endtask

  task automatic load_set(input logic [31:0] w);
    idle(10);
    do_cycle(0, 3'd0, 1, w, 0);
    do_cycle(0, 3'd0, 0, '0, 1);
    do_cycle(0, 3'd0, 0, '0, 0);
  endtask

  function automatic logic [31:0] pack(int cl, int rc, int ras, int rp, int rcd, int rrd, int dpl);
    return {1'b0, 3'(cl), 4'(rc), 4'(ras), 1'b0, 3'(rp), 1'b0, 3'(rcd),
            1'b0, 3'(rrd), 1'b0, 3'(dpl), 4'hF};
  endfunction

  function automatic logic [31:0] rand_set();
    return pack(2 + $urandom % 6, 1 + $urandom % 15, 1 + $urandom % 15,
                1 + $urandom % 7, 1 + $urandom % 7, 1 + $urandom % 7, 1 + $urandom % 7);
  endfunction

  task automatic stream(input int n);
    bit have = 0;
    logic [2:0] c = 3'd0;
    for (int i = 0; i < n; i++) begin
      if (!have) begin
        c = ($urandom % 100 < 5) ? 3'(6 + $urandom % 2) : 3'(1 + $urandom % 5);
        have = 1;
      end
      do_cycle($urandom % 5 != 0, c, 0, '0, 0);
      if (last_acc || $urandom % 4 == 0) have = 0;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_rd_data == 32'h2A733220, "R1", int'(cfg_rd_data), 32'h2A733220);
    check(cas_latency == 3'd2, "R1", int'(cas_latency), 2);
    check(load_err == 1'b0 && rd_valid == 1'b0, "R1", int'({load_err, rd_valid}), 0);
    cmd_code = 3'd1; #1;
    check(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);

    stream(400);                               // default timings
    // R2: write without apply leaves active timings alone
    do_cycle(0, 3'd0, 1, 32'hFFFF_FFFF, 0);
    idle(3);
    // R3: apply held high: second write does not get copied
    do_cycle(0, 3'd0, 0, '0, 1);
    do_cycle(0, 3'd0, 1, pack(5, 2, 2, 2, 2, 2, 2), 1);
    idle(3);
    check(cas_latency == 3'd7, "R3", int'(cas_latency), 7);
    stream(600);                               // all-maximum set (R5 extremes)
    load_set(pack(2, 1, 1, 1, 1, 1, 1));       // all-minimum set
    stream(600);
    // R4: refused loads keep old timings
    load_set(pack(4, 3, 3, 0, 3, 3, 3));
    load_set(pack(1, 3, 3, 3, 3, 3, 3));
    load_set(pack(4, 0, 3, 3, 3, 3, 3));
    load_set(pack(4, 3, 3, 3, 3, 3, 0));
    check(cas_latency == 3'd2, "R4", int'(cas_latency), 2);
    // R11: unsupported codes have no effect
    do_cycle(1, 3'd6, 0, '0, 0);
    do_cycle(1, 3'd0, 0, '0, 0);
    do_cycle(1, 3'd7, 0, '0, 0);
    for (int k = 0; k < 8; k++) begin
      load_set(rand_set());
      stream(1500);
    end
    idle(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule